// File: doc/BRIEF.md
# Block Residual Variable-Length Packer

This block turns one 8x8 block of prediction residuals into a compact, byte-aligned bit stream. It receives the whole block in one transfer, together with a 3-bit prediction mode and the raw initial pixel of the block. It splits the block into four 4x4 quadrants and gives each quadrant one code table. The table is chosen from the peak residual magnitude inside that quadrant. The block then emits the residuals as short codes, packed most significant bit first into bytes.

The stream is laid out in this order: a header made of the mode and the raw initial pixel, then the four quadrants. Each quadrant starts with its table index and is followed by its residual codes. Small magnitudes get short codes. Magnitudes above 32 take an escape that carries an order-0 Exp-Golomb value. A quadrant that holds only zeros costs only its index. The last byte is padded with zeros and flagged. One cycle after that byte is accepted, the block reports the total number of bytes.

Top module: `vlc_block_packer`

## Requirements
- R1: The stream starts with the 3-bit mode, then the (8-TRUNC_BITS)-bit initial pixel, each most significant bit first. Bits fill each output byte from bit 7 down to bit 0.
- R2: Quadrants follow in the order top-left, top-right, bottom-left, bottom-right. Each begins with its 3-bit table index, and its residuals are coded in raster order inside the quadrant.
- R3: The table index is 0 when the quadrant peak magnitude is 0. It is 1 to 5 for the smallest t with peak <= 2^t, and it is 6 when the peak exceeds 32. Index 7 is never sent.
- R4: For tables 1 to 6, let k = min(index, 5). A magnitude m <= 32 is coded as "0" when m < 2^k or "10" when m = 2^k, followed by the k low bits of m.
- R5: Under table 6, a magnitude m > 32 is coded as "11" followed by the order-0 Exp-Golomb code of m-33. That code is the bit length of m-32 minus one in zeros, then m-32 in binary.
- R6: A quadrant with table index 0 contributes no bits after its index.
- R7: The residual at row 0, column 0 (input slot 0) has no effect on the stream. It is left out of both the peak and the codes.
- R8: Every nonzero magnitude is followed by a sign bit, 1 for negative. The last byte of a block is padded with zero bits and is the only byte with out_last set.
- R9: One cycle after the last byte is accepted, len_valid_o pulses for one cycle with len_bytes_o equal to the number of bytes in the block.
- R10: While out_valid_o is high and out_ready_i is low, out_data_o and out_last_o hold their values.
- R11: blk_ready_o is high after reset. It stays low from the accepted block until that block's last byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid_i | input | 1 | A block is offered |
| blk_ready_o | output | 1 | The block can be taken |
| blk_mode_i | input | 3 | Prediction mode of the block |
| blk_ip_i | input | 8-TRUNC_BITS | Raw initial pixel |
| blk_res_i | input | 64*RES_W | Signed residuals, slot row*8+col at bits slot*RES_W |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Sink accepts the byte |
| out_data_o | output | 8 | Packed stream byte |
| out_last_o | output | 1 | Final byte of the block |
| len_valid_o | output | 1 | Byte count valid pulse |
| len_bytes_o | output | LEN_W | Bytes in the finished block |

## Verification
The assertions assume that every residual is a two's-complement value that fits in RES_W bits. They also assume that blk_valid_i, once raised, stays high with steady data until blk_ready_o is seen. The bench stays inside both rules: it draws residuals only from -256 to 255 and holds each offer until the block is taken. The sink is allowed to stall at any time. The bench drives out_ready_i with a periodic stall pattern so that the hold rule on the output bytes is exercised.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

  localparam int MAG_W  = 16;
  localparam int CODE_W = 40;
  localparam int CLEN_W = 6;

  typedef struct packed {
    logic [CLEN_W-1:0] len;
    logic [CODE_W-1:0] bits;
  } code_t;

  typedef enum logic [1:0] {G_IDLE, G_HDR, G_IDX, G_RES} gen_st_e;

  function automatic logic [MAG_W-1:0] mag_of(input logic [MAG_W-1:0] s);
    return s[MAG_W-1] ? (~s + 1'b1) : s;
  endfunction

  // smallest table whose range covers the peak
  function automatic logic [2:0] pick_table(input logic [MAG_W-1:0] peak);
    if (peak == '0)               return 3'd0;
    else if (peak <= MAG_W'(2))  return 3'd1;
    else if (peak <= MAG_W'(4))  return 3'd2;
    else if (peak <= MAG_W'(8))  return 3'd3;
    else if (peak <= MAG_W'(16)) return 3'd4;
    else if (peak <= MAG_W'(32)) return 3'd5;
    else                         return 3'd6;
  endfunction

  function automatic code_t make_code(input logic [MAG_W-1:0] m, input logic neg,
                                      input logic [2:0] tab);
    code_t c;
    int unsigned k;
    int unsigned nb;
    logic [MAG_W-1:0] x;
    c  = '0;
    k  = (tab > 3'd5) ? 5 : int'(tab);
    x  = '0;
    nb = 0;
    if (tab == 3'd6 && m > MAG_W'(32)) begin
      x = m - MAG_W'(32);
      for (int b = 0; b < MAG_W; b++) if (x[b]) nb = b + 1;
      c.bits = CODE_W'(3);
      c.bits = (c.bits << (2 * nb - 1)) | CODE_W'(x);
      c.len  = CLEN_W'(2 * nb + 1);
    end else begin
      if ((m >> k) != '0) begin
        c.bits = CODE_W'(2);
        c.len  = CLEN_W'(2);
      end else begin
        c.bits = '0;
        c.len  = CLEN_W'(1);
      end
      c.bits = (c.bits << k) | CODE_W'(m & ((MAG_W'(1) << k) - MAG_W'(1)));
      c.len  = c.len + CLEN_W'(k);
    end
    if (m != '0) begin
      c.bits = (c.bits << 1) | CODE_W'(neg);
      c.len  = c.len + CLEN_W'(1);
    end
    return c;
  endfunction

endpackage

// File: rtl/vlc_unit_sel.sv
module vlc_unit_sel #(
  parameter int RES_W      = 9,
  parameter int UNIT_N     = 16,
  parameter bit SKIP_FIRST = 1'b0
) (
  input  logic [UNIT_N*RES_W-1:0] res_i,
  output logic [2:0]              tab_o,
  output logic [15:0]             peak_o
);
  import vlc_pkg::*;

  always_comb begin
    logic [MAG_W-1:0] m;
    peak_o = '0;
    for (int j = 0; j < UNIT_N; j++) begin
      m = mag_of(MAG_W'($signed(res_i[j*RES_W +: RES_W])));
      if (!(SKIP_FIRST && j == 0) && m > peak_o) peak_o = m;
    end
    tab_o = pick_table(peak_o);
  end

endmodule

// File: rtl/vlc_sym_gen.sv
module vlc_sym_gen #(
  parameter int BLK_DIM = 8,
  parameter int RES_W   = 9,
  parameter int PIX_W   = 5
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 load_i,
  input  logic [2:0]                           mode_i,
  input  logic [PIX_W-1:0]                     ip_i,
  input  logic [BLK_DIM*BLK_DIM*RES_W-1:0]     res_i,
  output logic [BLK_DIM*BLK_DIM*RES_W-1:0]     res_q_o,
  input  logic [3:0][2:0]                      tabs_i,
  output logic                                 sym_valid_o,
  input  logic                                 sym_ready_i,
  output logic [vlc_pkg::CLEN_W-1:0]           sym_len_o,
  output logic [vlc_pkg::CODE_W-1:0]           sym_bits_o,
  output logic                                 sym_last_o,
  output logic                                 idle_o
);
  import vlc_pkg::*;

  localparam int UNIT_DIM = BLK_DIM / 2;
  localparam int UNIT_N   = UNIT_DIM * UNIT_DIM;
  localparam int NPIX     = BLK_DIM * BLK_DIM;
  localparam int IDX_W    = $clog2(UNIT_N);

  gen_st_e              st_q;
  logic [1:0]           unit_q;
  logic [IDX_W-1:0]     idx_q;
  logic [2:0]           mode_q;
  logic [PIX_W-1:0]     ip_q;
  logic [NPIX*RES_W-1:0] res_q;

  int                   pos;
  logic [MAG_W-1:0]     cur_sext;
  logic [MAG_W-1:0]     cur_mag;
  code_t                cur_code;
  logic [2:0]           cur_tab;
  logic                 sym_fire;
  logic                 unit_end;
  logic                 blk_end;

  assign res_q_o  = res_q;
  assign cur_tab  = tabs_i[unit_q];
  assign sym_fire = sym_valid_o && sym_ready_i;
  assign unit_end = (int'(idx_q) == UNIT_N - 1);
  assign blk_end  = (unit_q == 2'd3);
  assign idle_o   = (st_q == G_IDLE);

  always_comb begin
    pos = ((int'(unit_q[1]) * UNIT_DIM) + int'(idx_q) / UNIT_DIM) * BLK_DIM
        + int'(unit_q[0]) * UNIT_DIM + int'(idx_q) % UNIT_DIM;
    cur_sext = MAG_W'($signed(res_q[pos*RES_W +: RES_W]));
    cur_mag  = mag_of(cur_sext);
    cur_code = make_code(cur_mag, cur_sext[MAG_W-1], cur_tab);
  end

  always_comb begin
    sym_valid_o = 1'b0;
    sym_len_o   = '0;
    sym_bits_o  = '0;
    sym_last_o  = 1'b0;
    unique case (st_q)
      G_HDR: begin
        sym_valid_o = 1'b1;
        sym_len_o   = CLEN_W'(3 + PIX_W);
        sym_bits_o  = CODE_W'({mode_q, ip_q});
      end
      G_IDX: begin
        sym_valid_o = 1'b1;
        sym_len_o   = CLEN_W'(3);
        sym_bits_o  = CODE_W'(cur_tab);
        sym_last_o  = blk_end && (cur_tab == 3'd0);
      end
      G_RES: begin
        sym_valid_o = 1'b1;
        sym_len_o   = cur_code.len;
        sym_bits_o  = cur_code.bits;
        sym_last_o  = blk_end && unit_end;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= G_IDLE;
      unit_q <= '0;
      idx_q  <= '0;
      mode_q <= '0;
      ip_q   <= '0;
      res_q  <= '0;
    end else begin
      unique case (st_q)
        G_IDLE: if (load_i) begin
          mode_q <= mode_i;
          ip_q   <= ip_i;
          res_q  <= res_i;
          unit_q <= '0;
          st_q   <= G_HDR;
        end
        G_HDR: if (sym_fire) st_q <= G_IDX;
        G_IDX: if (sym_fire) begin
          if (cur_tab == 3'd0) begin
            if (blk_end) st_q <= G_IDLE;
            else unit_q <= unit_q + 2'd1;
          end else begin
            // the initial pixel slot opens quadrant 0 and is never coded
            idx_q <= (unit_q == 2'd0) ? IDX_W'(1) : '0;
            st_q  <= G_RES;
          end
        end
        G_RES: if (sym_fire) begin
          if (unit_end) begin
            if (blk_end) st_q <= G_IDLE;
            else begin
              unit_q <= unit_q + 2'd1;
              st_q   <= G_IDX;
            end
          end else idx_q <= idx_q + IDX_W'(1);
        end
        default: st_q <= G_IDLE;
      endcase
    end
  end

  AST_SYM_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |-> sym_len_o != '0); // R6
  AST_IDX_NOT_SEVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_o && st_q == G_IDX) |-> sym_bits_o[2:0] != 3'd7); // R3
  AST_SYM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_o && !sym_ready_i) |=> sym_valid_o && $stable(sym_bits_o) && $stable(sym_len_o)); // R10

endmodule

// File: rtl/vlc_bit_packer.sv
module vlc_bit_packer #(
  parameter int CODE_W = 40,
  parameter int CLEN_W = 6,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_valid_i,
  output logic              sym_ready_o,
  input  logic [CLEN_W-1:0] sym_len_i,
  input  logic [CODE_W-1:0] sym_bits_i,
  input  logic              sym_last_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [7:0]        out_data_o,
  output logic              out_last_o,
  output logic              len_valid_o,
  output logic [LEN_W-1:0]  len_bytes_o,
  output logic              idle_o
);
  localparam int ACC_W = CODE_W + 8;
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [LEN_W-1:0] nbytes_q;

  logic             sym_fire;
  logic             byte_fire;
  logic             full_byte;
  logic [ACC_W-1:0] placed;
  int               sh;

  assign full_byte   = (int'(cnt_q) >= 8);
  assign sym_ready_o = !done_q && !full_byte;
  assign sym_fire    = sym_valid_i && sym_ready_o;
  assign out_valid_o = full_byte || (done_q && cnt_q != '0);
  assign out_data_o  = acc_q[ACC_W-1 -: 8];
  assign out_last_o  = done_q && (int'(cnt_q) <= 8) && (cnt_q != '0);
  assign byte_fire   = out_valid_o && out_ready_i;
  assign idle_o      = !done_q && (cnt_q == '0);

  always_comb begin
    sh     = ACC_W - int'(cnt_q) - int'(sym_len_i);
    placed = ACC_W'(sym_bits_i) << sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      cnt_q       <= '0;
      done_q      <= 1'b0;
      nbytes_q    <= '0;
      len_valid_o <= 1'b0;
      len_bytes_o <= '0;
    end else begin
      len_valid_o <= 1'b0;
      if (sym_fire) begin
        acc_q  <= acc_q | placed;
        cnt_q  <= cnt_q + CNT_W'(sym_len_i);
        done_q <= sym_last_i;
      end else if (byte_fire) begin
        acc_q    <= acc_q << 8;
        cnt_q    <= full_byte ? cnt_q - CNT_W'(8) : '0;
        nbytes_q <= nbytes_q + LEN_W'(1);
        if (out_last_o) begin
          done_q      <= 1'b0;
          len_valid_o <= 1'b1;
          len_bytes_o <= nbytes_q + LEN_W'(1);
          nbytes_q    <= '0;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sym_fire |-> (int'(cnt_q) + int'(sym_len_i)) <= ACC_W); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o)); // R10
  AST_LEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_fire && out_last_o) |=> len_valid_o); // R9
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && done_q && !full_byte) |-> (out_data_o & (8'hFF >> cnt_q)) == 8'h00); // R8

endmodule

// File: rtl/vlc_block_packer.sv
module vlc_block_packer #(
  parameter  int BLK_DIM    = 8,
  parameter  int RES_W      = 9,
  parameter  int TRUNC_BITS = 3,
  localparam int PIX_W      = 8 - TRUNC_BITS,
  localparam int NPIX       = BLK_DIM * BLK_DIM,
  localparam int MAX_BITS   = 3 + PIX_W + 4 * 3 + (NPIX - 1) * (2 * RES_W + 2),
  localparam int LEN_W      = $clog2(MAX_BITS / 8 + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  blk_valid_i,
  output logic                  blk_ready_o,
  input  logic [2:0]            blk_mode_i,
  input  logic [PIX_W-1:0]      blk_ip_i,
  input  logic [NPIX*RES_W-1:0] blk_res_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [7:0]            out_data_o,
  output logic                  out_last_o,
  output logic                  len_valid_o,
  output logic [LEN_W-1:0]      len_bytes_o
);
  import vlc_pkg::*;

  localparam int UNIT_DIM = BLK_DIM / 2;
  localparam int UNIT_N   = UNIT_DIM * UNIT_DIM;

  logic [NPIX*RES_W-1:0] res_q;
  logic [3:0][2:0]       tabs;
  logic [3:0][15:0]      peaks;
  logic                  gen_idle;
  logic                  pk_idle;
  logic                  load;
  logic                  sym_valid;
  logic                  sym_ready;
  logic [CLEN_W-1:0]     sym_len;
  logic [CODE_W-1:0]     sym_bits;
  logic                  sym_last;

  assign blk_ready_o = gen_idle && pk_idle;
  assign load        = blk_valid_i && blk_ready_o;

  for (genvar u = 0; u < 4; u++) begin : g_unit
    logic [UNIT_N*RES_W-1:0] slice;
    for (genvar j = 0; j < UNIT_N; j++) begin : g_px
      localparam int POS = ((u / 2) * UNIT_DIM + j / UNIT_DIM) * BLK_DIM
                         + (u % 2) * UNIT_DIM + j % UNIT_DIM;
      assign slice[j*RES_W +: RES_W] = res_q[POS*RES_W +: RES_W];
    end
    vlc_unit_sel #(.RES_W(RES_W), .UNIT_N(UNIT_N), .SKIP_FIRST(u == 0)) u_sel (
      .res_i (slice),
      .tab_o (tabs[u]),
      .peak_o(peaks[u])
    );
  end

  vlc_sym_gen #(.BLK_DIM(BLK_DIM), .RES_W(RES_W), .PIX_W(PIX_W)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .mode_i     (blk_mode_i),
    .ip_i       (blk_ip_i),
    .res_i      (blk_res_i),
    .res_q_o    (res_q),
    .tabs_i     (tabs),
    .sym_valid_o(sym_valid),
    .sym_ready_i(sym_ready),
    .sym_len_o  (sym_len),
    .sym_bits_o (sym_bits),
    .sym_last_o (sym_last),
    .idle_o     (gen_idle)
  );

  vlc_bit_packer #(.CODE_W(CODE_W), .CLEN_W(CLEN_W), .LEN_W(LEN_W)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_valid_i(sym_valid),
    .sym_ready_o(sym_ready),
    .sym_len_i  (sym_len),
    .sym_bits_i (sym_bits),
    .sym_last_i (sym_last),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (out_data_o),
    .out_last_o (out_last_o),
    .len_valid_o(len_valid_o),
    .len_bytes_o(len_bytes_o),
    .idle_o     (pk_idle)
  );

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> !blk_ready_o); // R11
  AST_PEAK_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_idle && tabs[0] != 3'd0 && tabs[0] != 3'd6) |-> peaks[0] <= (16'd1 << tabs[0])); // R3

endmodule

// File: tb/vlc_block_packer_tb.sv
module vlc_block_packer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 9;
  localparam int PIX_W = 5;
  localparam int NPIX  = 64;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_valid = 1'b0;
  logic blk_ready;
  logic [2:0] blk_mode = '0;
  logic [PIX_W-1:0] blk_ip = '0;
  logic [NPIX*RES_W-1:0] blk_res = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic out_last;
  logic len_valid;
  logic [LEN_W-1:0] len_bytes;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlc_block_packer u_dut (
    .clk(clk), .rst_n(rst_n), .blk_valid_i(blk_valid), .blk_ready_o(blk_ready),
    .blk_mode_i(blk_mode), .blk_ip_i(blk_ip), .blk_res_i(blk_res),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_last_o(out_last), .len_valid_o(len_valid), .len_bytes_o(len_bytes)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  bit stall_mode = 0;
  int res [NPIX];
  bit mbits[$];
  int exp_q[$];
  int len_q[$];
  int seed = 32'h1234_5678;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 32'h7fff;
  endfunction

  function automatic int posof(input int u, input int j);
    return ((u / 2) * 4 + j / 4) * 8 + (u % 2) * 4 + j % 4;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic putv(input int v, input int n);
    for (int b = n - 1; b >= 0; b--) mbits.push_back(v[b]);
  endtask

  // reference stream built straight from R1..R8
  task automatic model(input int mode, input int ip);
    int peak, t, k, m, x, nb, nbytes, by;
    mbits.delete();
    putv(mode, 3);
    putv(ip, PIX_W);                                // R1
    for (int u = 0; u < 4; u++) begin               // R2 quadrant order
      peak = 0;
      for (int j = 0; j < 16; j++)
        if (!(u == 0 && j == 0) && iabs(res[posof(u, j)]) > peak) peak = iabs(res[posof(u, j)]); // R7
      if (peak == 0) t = 0;                         // R3
      else begin
        t = 6;
        for (int c = 5; c >= 1; c--) if (peak <= (1 << c)) t = c;
      end
      putv(t, 3);
      if (t == 0) continue;                         // R6
      k = (t > 5) ? 5 : t;
      for (int j = 0; j < 16; j++) begin
        if (u == 0 && j == 0) continue;
        m = iabs(res[posof(u, j)]);
        if (t == 6 && m > 32) begin                 // R5
          x = m - 32;
          nb = $clog2(x + 1);
          putv(3, 2);
          putv(0, nb - 1);
          putv(x, nb);
        end else begin                              // R4
          if ((m >> k) != 0) putv(2, 2); else putv(0, 1);
          putv(m, k);
        end
        if (m != 0) putv(res[posof(u, j)] < 0, 1);  // R8 sign
      end
    end
    while (mbits.size() % 8 != 0) mbits.push_back(1'b0); // R8 padding
    nbytes = mbits.size() / 8;
    for (int i = 0; i < nbytes; i++) begin
      by = 0;
      for (int b = 0; b < 8; b++) by = (by << 1) | int'(mbits[i*8 + b]);
      exp_q.push_back(by | ((i == nbytes - 1) ? 256 : 0));
    end
    len_q.push_back(nbytes);
  endtask

  task automatic send(input int mode, input int ip);
    model(mode, ip);
    @(negedge clk);
    blk_mode = 3'(mode);
    blk_ip   = PIX_W'(ip);
    for (int p = 0; p < NPIX; p++) blk_res[p*RES_W +: RES_W] = RES_W'(res[p]);
    blk_valid = 1'b1;
    while (!blk_ready) @(negedge clk);
    @(negedge clk);
    blk_valid = 1'b0;
  endtask

  task automatic fill_unit(input int u, input int peak);
    for (int j = 0; j < 16; j++) begin
      res[posof(u, j)] = (peak == 0) ? 0 : ((j * 7) % (peak + 1));
      if (j % 2 == 1) res[posof(u, j)] = -res[posof(u, j)];
    end
    if (peak != 0) res[posof(u, 5)] = -peak;
  endtask

  // scoreboard monitor
  initial begin
    bit pv = 0, pr = 0, pl = 0, len_pend = 0;
    int pd = 0, exp_len = 0, item, cyc = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      cyc++;
      if (len_pend) begin
        check(len_valid === 1'b1 && int'(len_bytes) == exp_len, "R9 length", int'(len_bytes), exp_len);
        len_pend = 0;
      end
      if (pv && !pr) // R10 hold under stall
        check(out_valid && int'(out_data) == pd && out_last == pl, "R10 hold", int'(out_data), pd);
      out_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
      if (out_valid) check(!blk_ready, "R11 busy", int'(blk_ready), 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R2 extra byte", int'(out_data), -1);
        else begin
          item = exp_q.pop_front();
          check(int'(out_data) == (item & 255), "R1/R2/R3/R4/R5/R6/R7 byte", int'(out_data), item & 255);
          check(out_last == item[8], "R8 last", int'(out_last), item[8]);
          if (item[8]) begin
            exp_len = len_q.pop_front();
            len_pend = 1;
          end
        end
      end
      pv = out_valid; pr = out_ready; pd = int'(out_data); pl = out_last;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog R11", 0, 1);
    finish_run();
  end

  initial begin
    int amp;
    repeat (3) @(negedge clk);
    check(!out_valid && blk_ready && !len_valid, "R11 reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(blk_ready === 1'b1, "R11 ready idle", int'(blk_ready), 1);

    // R6/R7: all zero except the ignored slot 0
    for (int p = 0; p < NPIX; p++) res[p] = 0;
    res[0] = 77;
    send(5, 19);
    // R3/R4 small peaks 1..4, slot 0 huge but ignored
    fill_unit(0, 1); fill_unit(1, 2); fill_unit(2, 3); fill_unit(3, 4);
    res[0] = -200;
    send(2, 31);
    // R3 boundaries 8/9/16/17
    fill_unit(0, 8); fill_unit(1, 9); fill_unit(2, 16); fill_unit(3, 17);
    send(7, 0);
    // R5 escape path: 32, 33, extremes
    fill_unit(0, 32); fill_unit(1, 33); fill_unit(2, 256); fill_unit(3, 0);
    res[posof(3, 15)] = 255;
    res[posof(2, 0)]  = 100;
    send(1, 12);
    stall_mode = 1;
    send(3, 3);
    for (int b = 0; b < 10; b++) begin
      case (b % 5)
        0: amp = 1; 1: amp = 6; 2: amp = 20; 3: amp = 40; default: amp = 255;
      endcase
      for (int p = 0; p < NPIX; p++) res[p] = (rnd() % (2 * amp + 1)) - amp;
      if (b == 3) fill_unit(1, 0);
      stall_mode = b[0];
      send(rnd() % 8, rnd() % 32);
    end
    while (exp_q.size() != 0 || len_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(blk_ready === 1'b1, "R11 ready after", int'(blk_ready), 1);
    finish_run();
  end
endmodule